// File: doc/BRIEF.md
# RTC Tick Trimmer with Calibration Output Pin

This block sits on the tick stream of a real-time clock and slows it down by a small, programmed amount. It counts incoming clock-enable pulses in a fixed window of 2^WIN_W ticks and withholds a programmed number of them, so the corrected tick stream runs slow by that many ticks per window. With the default sizes (20-bit window, 7-bit trim value) one trim step is one tick in 2^20, about 0.954 ppm. The largest value, 127, is about 121 ppm. The withheld ticks are spread out: the window is cut into 2^CAL_W equal sub-intervals, and the first tick of each of the first CAL of them is dropped.

The block also drives a shared output pin that can carry one of three signals. The first is the raw tick stream divided by 64, for measuring the clock. The second is an alarm pulse and the third is a seconds pulse, each stretched to exactly one tick period. All state lives in the backup domain and is cleared only by the backup-domain reset. The block is clocked by a fast clock `clk`, and `rtc_ce` marks the RTC ticks.

Top module: `rtc_trim_out`

## Requirements
- R1: `corr_ce` is high only in the cycle after a cycle in which `rtc_ce` was high. It then repeats that tick unless the tick is dropped.
- R2: Ticks are numbered 0 to 2^WIN_W-1 within the window, and the window is cut into 2^CAL_W sub-intervals of 2^(WIN_W-CAL_W) ticks. The tick numbered k·2^(WIN_W-CAL_W) is dropped exactly when k is below the active trim value, so a window passes 2^WIN_W minus that value ticks.
- R3: `cal_val` is taken as the active trim value on the last tick of each window. A change in the middle of a window therefore acts only from the next window, and the first window after the backup reset uses a trim value of 0.
- R4: With `cco_en`=1, `pin_oe`=1 and `pin_out` equals bit 5 of the count of `rtc_ce` ticks since the backup reset. This is the tick rate divided by 64 with a 50% duty cycle.
- R5: When `cco_en` and `aso_en` are both 1, the pin carries the divided clock.
- R6: With `cco_en`=0 and `aso_en`=1, `aso_sel`=0 puts the alarm pulse on the pin and `aso_sel`=1 puts the seconds pulse on the pin. A strobe from the source that is not selected leaves `pin_out` at 0.
- R7: A strobe is registered only in a cycle where `rtc_ce` is high. The pulse then goes high in the next cycle and falls in the cycle after the next tick, which lasts exactly one tick period.
- R8: With `cco_en`=0 and `aso_en`=0, `pin_oe`=0 and `pin_out`=0, even while a pulse is stretched internally.
- R9: The backup reset (`bkp_rst_n`=0, synchronous) clears the window position, the active trim value, the divider and both pulse stretchers, and drives `corr_ce` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| bkp_rst_n | input | 1 | Backup-domain reset, synchronous, active low |
| rtc_ce | input | 1 | One-cycle enable marking each raw RTC tick |
| alarm_stb | input | 1 | Alarm event strobe, aligned to a tick |
| second_stb | input | 1 | Seconds event strobe, aligned to a tick |
| cal_val | input | CAL_W | Number of ticks to drop per window |
| cco_en | input | 1 | Route the divided clock to the pin |
| aso_en | input | 1 | Route the alarm or seconds pulse to the pin |
| aso_sel | input | 1 | 0 = alarm pulse, 1 = seconds pulse |
| corr_ce | output | 1 | Trimmed tick enable, one cycle after `rtc_ce` |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |

## Verification
The checker watches every cycle for four things:
- a corrected tick that has no raw tick behind it;
- two dropped ticks closer together than one sub-interval;
- a pulse on the pin that starts or ends other than on a tick;
- a change of the divided clock between ticks.

Other properties depend on counting over whole windows and on the program history, and only the bench's scenarios show them. These are the exact number and the positions of the dropped ticks, the deferral of a trim change to the window boundary, the source priority on the pin, and the clearing done by the backup reset. The bench follows a reference model tick by tick through several full windows at a reduced window size.

// File: rtl/rtc_trim_pkg.sv
// Shared types for the RTC tick trimmer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package rtc_trim_pkg;

    // Source driven onto the shared output pin.
    typedef enum logic [1:0] {
        PIN_OFF   = 2'd0,
        PIN_DIV   = 2'd1,
        PIN_ALARM = 2'd2,
        PIN_SEC   = 2'd3
    } pin_src_e;

    // Pick the pin source; the divided clock outranks the event pulses.
    function automatic pin_src_e pick_src(input logic div_on,
                                          input logic evt_on,
                                          input logic evt_sec);
        pin_src_e s;
        if (div_on)
            s = PIN_DIV;
        else if (evt_on)
            s = evt_sec ? PIN_SEC : PIN_ALARM;
        else
            s = PIN_OFF;
        return s;
    endfunction

endpackage

// File: rtl/rtc_swallow.sv
// Window-based tick dropper.
// Counts raw ticks in a window of 2^WIN_W and drops the first tick of each
// of the first cal_q sub-intervals. cal_in is sampled on the last tick of a
// window, so the trim value is constant across a window.
// Assumes: tick is a single-cycle enable; WIN_W >= CAL_W.
module rtc_swallow #(
    parameter int CAL_W = 7,
    parameter int WIN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CAL_W-1:0] cal_in,
    output logic             corr_ce
);
    localparam int SUB_W = WIN_W - CAL_W;

    logic [WIN_W-1:0] win_q;
    logic [CAL_W-1:0] cal_q;
    logic [CAL_W-1:0] sub_idx;
    logic             sub_first;
    logic             win_last;
    logic             drop;

    // Decode the sub-interval start; a width of zero means every tick starts one.
    generate
        if (SUB_W > 0) begin : g_sub
            assign sub_first = (win_q[SUB_W-1:0] == '0);
        end else begin : g_nosub
            assign sub_first = 1'b1;
        end
    endgenerate

    assign sub_idx  = win_q[WIN_W-1:SUB_W];
    assign win_last = &win_q;
    assign drop     = sub_first && (sub_idx < cal_q);

    // Advance the window position on every raw tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= '0;
        else if (tick)
            win_q <= win_q + 1'b1;
    end

    // Adopt a new trim value only as the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cal_q <= '0;
        else if (tick && win_last)
            cal_q <= cal_in;
    end

    // Register the trimmed tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            corr_ce <= 1'b0;
        else
            corr_ce <= tick && !drop;
    end

endmodule

// File: rtl/rtc_tick_div.sv
// Power-of-two divider of the raw tick stream.
// The output is the top bit of a free-running tick counter, giving a square
// wave at the tick rate over 2^DIV_W with a 50% duty cycle.
// Assumes: tick is a single-cycle enable.
module rtc_tick_div #(
    parameter int DIV_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic div_out
);
    logic [DIV_W-1:0] cnt_q;

    // Count raw ticks, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign div_out = cnt_q[DIV_W-1];

endmodule

// File: rtl/rtc_evt_stretch.sv
// Stretches a tick-aligned event strobe to one full tick period.
// Sets on a strobe that arrives together with a tick and clears on the next
// tick that carries no strobe.
// Assumes: strobes outside a tick cycle are not meaningful and are ignored.
module rtc_evt_stretch (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic stb,
    output logic pulse
);
    // Hold the pulse from one tick to the next.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse <= 1'b0;
        else if (tick)
            pulse <= stb;
    end

endmodule

// File: rtl/rtc_trim_out.sv
// Top of the RTC tick trimmer with its calibration output pin.
// Holds the tick dropper, the divide-by-2^DIV_W clock output and two event
// stretchers, and multiplexes one of them onto the pin.
// Assumes: a single clock; rtc_ce is a one-cycle enable; bkp_rst_n is the
// backup-domain reset and is synchronous.
module rtc_trim_out
    import rtc_trim_pkg::*;
#(
    parameter int CAL_W = 7,
    parameter int WIN_W = 20,
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             bkp_rst_n,
    input  logic             rtc_ce,
    input  logic             alarm_stb,
    input  logic             second_stb,
    input  logic [CAL_W-1:0] cal_val,
    input  logic             cco_en,
    input  logic             aso_en,
    input  logic             aso_sel,
    output logic             corr_ce,
    output logic             pin_out,
    output logic             pin_oe
);
    localparam int N_EVT = 2;

    logic             div_clk;
    logic [N_EVT-1:0] evt_stb;
    logic [N_EVT-1:0] evt_pulse;
    pin_src_e         src;

    assign evt_stb = {second_stb, alarm_stb};

    rtc_swallow #(
        .CAL_W (CAL_W),
        .WIN_W (WIN_W)
    ) u_swallow (
        .clk     (clk),
        .rst_n   (bkp_rst_n),
        .tick    (rtc_ce),
        .cal_in  (cal_val),
        .corr_ce (corr_ce)
    );

    rtc_tick_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (bkp_rst_n),
        .tick    (rtc_ce),
        .div_out (div_clk)
    );

    // Slot 0 holds the alarm stretcher, slot 1 the seconds stretcher.
    generate
        for (genvar g = 0; g < N_EVT; g++) begin : g_evt
            rtc_evt_stretch u_str (
                .clk   (clk),
                .rst_n (bkp_rst_n),
                .tick  (rtc_ce),
                .stb   (evt_stb[g]),
                .pulse (evt_pulse[g])
            );
        end
    endgenerate

    // Drive the pin from the selected source.
    always_comb begin
        src = pick_src(cco_en, aso_en, aso_sel);
        unique case (src)
            PIN_DIV:   begin pin_oe = 1'b1; pin_out = div_clk;      end
            PIN_ALARM: begin pin_oe = 1'b1; pin_out = evt_pulse[0]; end
            PIN_SEC:   begin pin_oe = 1'b1; pin_out = evt_pulse[1]; end
            default:   begin pin_oe = 1'b0; pin_out = 1'b0;         end
        endcase
    end

endmodule

// File: rtl/rtc_trim_chk.sv
// Assertion checker for rtc_trim_out, attached by bind.
// Watches tick alignment of the corrected stream, the spacing of dropped
// ticks, and the edge timing of the pin in its pulse and clock modes.
module rtc_trim_chk #(
    parameter int CAL_W = 7,
    parameter int WIN_W = 20,
    parameter int DIV_W = 6
) (
    input logic clk,
    input logic bkp_rst_n,
    input logic rtc_ce,
    input logic cco_en,
    input logic aso_en,
    input logic aso_sel,
    input logic corr_ce,
    input logic pin_out
);
    localparam int SUB_W = WIN_W - CAL_W;
    localparam int GAP_MIN = (1 << SUB_W) - 1;

    logic             ce_d;
    logic             seen_drop;
    logic [WIN_W:0]   gap_q;
    logic             drop_ev;

    assign drop_ev = ce_d && !corr_ce;

    // Remember the previous tick and count passed ticks since the last drop.
    always_ff @(posedge clk) begin
        if (!bkp_rst_n) begin
            ce_d      <= 1'b0;
            seen_drop <= 1'b0;
            gap_q     <= '0;
        end else begin
            ce_d <= rtc_ce;
            if (drop_ev) begin
                seen_drop <= 1'b1;
                gap_q     <= '0;
            end else if (ce_d && !(&gap_q)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_CORR_FROM_TICK: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        corr_ce |-> $past(rtc_ce)); // R1

    AST_DROP_SPACING: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (drop_ev && seen_drop) |-> (gap_q >= (WIN_W+1)'(GAP_MIN))); // R2

    AST_PULSE_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (aso_en && !cco_en && $stable(aso_en) && $stable(cco_en) && $stable(aso_sel)
         && $rose(pin_out)) |-> $past(rtc_ce)); // R7

    AST_PULSE_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (aso_en && !cco_en && $stable(aso_en) && $stable(cco_en) && $stable(aso_sel)
         && $fell(pin_out)) |-> $past(rtc_ce)); // R7

    AST_DIV_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (cco_en && $past(cco_en) && !$past(rtc_ce)) |-> $stable(pin_out)); // R4

endmodule

bind rtc_trim_out rtc_trim_chk #(
    .CAL_W (CAL_W),
    .WIN_W (WIN_W),
    .DIV_W (DIV_W)
) u_chk (
    .clk       (clk),
    .bkp_rst_n (bkp_rst_n),
    .rtc_ce    (rtc_ce),
    .cco_en    (cco_en),
    .aso_en    (aso_en),
    .aso_sel   (aso_sel),
    .corr_ce   (corr_ce),
    .pin_out   (pin_out)
);

// File: tb/sim_rtc_trim_out.sv
// Bench for rtc_trim_out at a reduced window (2^10 ticks, 8-tick sub-intervals).
module sim_rtc_trim_out;
    localparam int CLK_PERIOD = 10;
    localparam int CAL_W = 7;
    localparam int WIN_W = 10;
    localparam int DIV_W = 6;
    localparam int WIN = 1 << WIN_W;
    localparam int SUB = 1 << (WIN_W - CAL_W);
    localparam int WATCHDOG = 150000;

    logic             clk = 1'b0;
    logic             bkp_rst_n = 1'b0;
    logic             rtc_ce = 1'b0;
    logic             alarm_stb = 1'b0;
    logic             second_stb = 1'b0;
    logic [CAL_W-1:0] cal_val = '0;
    logic             cco_en = 1'b0;
    logic             aso_en = 1'b0;
    logic             aso_sel = 1'b0;
    logic             corr_ce;
    logic             pin_out;
    logic             pin_oe;

    int checks = 0;
    int errors = 0;
    int win_idx = 0;
    int cal_model = 0;
    int ticks_total = 0;
    int corr_bad = 0;
    int kept = 0;
    int div_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    rtc_trim_out #(.CAL_W(CAL_W), .WIN_W(WIN_W), .DIV_W(DIV_W)) u0 (
        .clk(clk), .bkp_rst_n(bkp_rst_n), .rtc_ce(rtc_ce),
        .alarm_stb(alarm_stb), .second_stb(second_stb), .cal_val(cal_val),
        .cco_en(cco_en), .aso_en(aso_en), .aso_sel(aso_sel),
        .corr_ce(corr_ce), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One raw tick with the model of the dropper (R1, R2, R3) run alongside.
    task automatic do_tick(input bit a, input bit s);
        bit exp_c;
        exp_c = !(((win_idx % SUB) == 0) && ((win_idx / SUB) < cal_model));
        rtc_ce = 1'b1; alarm_stb = a; second_stb = s;
        @(negedge clk);
        if (corr_ce !== exp_c) corr_bad++;
        if (corr_ce) kept++;
        rtc_ce = 1'b0; alarm_stb = 1'b0; second_stb = 1'b0;
        if (win_idx == WIN - 1) begin
            win_idx = 0;
            cal_model = int'(cal_val);
        end else begin
            win_idx++;
        end
        ticks_total++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        bkp_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        win_idx = 0; cal_model = 0; ticks_total = 0;
    endtask

    initial begin
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seq [9] = '{5, 1, 2, 3, 64, 126, 127, 9, 0};
        // Reset state (R9, R8).
        cal_val = 7'd5;
        do_reset();
        check(corr_ce === 1'b0, "R9 corr_ce in reset", corr_ce, 0);
        check(pin_oe === 1'b0 && pin_out === 1'b0, "R8 pin idle", {pin_oe, pin_out}, 0);
        bkp_rst_n = 1'b1;
        @(negedge clk);

        // Windows: each changes cal mid-window, so it applies one window later (R2, R3).
        for (int i = 0; i < 9; i++) begin
            int exp_keep;
            exp_keep = WIN - cal_model;
            kept = 0;
            for (int t = 0; t < WIN; t++) begin
                if (t == 500 && i < 8) cal_val = 7'(seq[i+1]);
                do_tick(1'b0, 1'b0);
            end
            check(kept == exp_keep, "R2/R3 ticks kept per window", kept, exp_keep);
        end
        check(corr_bad == 0, "R1/R2 dropped tick positions", corr_bad, 0);

        // Divided clock (R4) then priority over the pulses (R5).
        cco_en = 1'b1;
        @(negedge clk);
        for (int t = 0; t < 130; t++) begin
            do_tick(1'b0, 1'b0);
            if (pin_out !== 1'((ticks_total >> 5) & 1) || pin_oe !== 1'b1) div_bad++;
        end
        check(div_bad == 0, "R4 divide by 64", div_bad, 0);
        aso_en = 1'b1;
        div_bad = 0;
        for (int t = 0; t < 70; t++) begin
            do_tick(t[0], !t[0]);
            if (pin_out !== 1'((ticks_total >> 5) & 1) || pin_oe !== 1'b1) div_bad++;
        end
        check(div_bad == 0, "R5 divided clock outranks pulses", div_bad, 0);

        // Alarm pulse length (R7, R6).
        cco_en = 1'b0; aso_sel = 1'b0;
        do_tick(1'b0, 1'b0);
        check(pin_out === 1'b0 && pin_oe === 1'b1, "R6 alarm idle", pin_out, 0);
        do_tick(1'b1, 1'b0);
        check(pin_out === 1'b1, "R7 alarm pulse high after tick", pin_out, 1);
        repeat (3) @(negedge clk);
        check(pin_out === 1'b1, "R7 alarm pulse held between ticks", pin_out, 1);
        do_tick(1'b0, 1'b0);
        check(pin_out === 1'b0, "R7 alarm pulse ends at next tick", pin_out, 0);
        // Unselected strobe ignored, seconds pulse shown (R6).
        aso_sel = 1'b1;
        do_tick(1'b1, 1'b0);
        check(pin_out === 1'b0, "R6 alarm ignored when seconds selected", pin_out, 0);
        do_tick(1'b0, 1'b0);
        do_tick(1'b0, 1'b1);
        check(pin_out === 1'b1, "R6 seconds pulse on pin", pin_out, 1);
        do_tick(1'b0, 1'b0);
        check(pin_out === 1'b0, "R7 seconds pulse one tick long", pin_out, 0);
        aso_sel = 1'b0;
        do_tick(1'b0, 1'b1);
        check(pin_out === 1'b0, "R6 seconds ignored when alarm selected", pin_out, 0);
        do_tick(1'b0, 1'b0);

        // Pin disabled while a pulse is stretched (R8).
        do_tick(1'b1, 1'b0);
        aso_en = 1'b0;
        @(negedge clk);
        check(pin_oe === 1'b0 && pin_out === 1'b0, "R8 pin off with pulse held", {pin_oe, pin_out}, 0);

        // Backup reset mid-run clears everything (R9, R3).
        cal_val = 7'd5;
        repeat (40) do_tick(1'b0, 1'b0);
        do_reset();
        cco_en = 1'b1;
        @(negedge clk);
        check(corr_ce === 1'b0 && pin_out === 1'b0, "R9 divider and corr cleared", {corr_ce, pin_out}, 0);
        cco_en = 1'b0;
        bkp_rst_n = 1'b1;
        kept = 0;
        for (int t = 0; t < WIN; t++) do_tick(1'b0, 1'b0);
        check(kept == WIN, "R3 first window after reset untrimmed", kept, WIN);
        kept = 0;
        for (int t = 0; t < WIN; t++) do_tick(1'b0, 1'b0);
        check(kept == WIN - 5, "R3 trim applied in second window", kept, WIN - 5);
        check(corr_bad == 0, "R1 corrected tick stream", corr_bad, 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule